// File: doc/BRIEF.md
# Status Register and Write-Protection Unit

This unit sits beside the command decoder of a serial nonvolatile memory. It keeps the volatile write-enable latch and three nonvolatile control bits: a protect-pin enable and a two-bit block-protection level. From them it builds the eight-bit status byte returned to a status read, and it decides two things. The first is whether a status write may be accepted now. The second is whether a candidate array address falls inside the protected region.

A status write is taken in while chip select is low, held as pending, and committed only when chip select returns high. The commit emits a one-cycle pulse that starts the self-timed busy cycle. If the hardware lock engages before the commit, the pending write is dropped. The external programming timer drives `busy`. The end of any busy cycle clears the write-enable latch.

The protected region is always a high-address slice of the array. With level 1 it is the top quarter, with level 2 the top half, and with level 3 the whole array. Its size follows the `ADDR_W` parameter.

Top module: `sr_guard`

## Requirements
- R1: When `busy` is 0 the status byte is {bit7 = protect-pin enable, bits 6..4 = 0, bits 3..2 = protection level, bit1 = write-enable latch, bit0 = 0}.
- R2: While `busy` is 1 the status byte is 8'hFF.
- R3: After reset the write-enable latch is 0. A `wel_set` pulse sets it on the next cycle. A `wel_clr` pulse clears it on the next cycle whatever the level of `wp_n`.
- R4: The cycle after `busy` falls, the write-enable latch reads 0.
- R5: `sr_permit` is 1 exactly when the latch is set, `busy` is 0, and the hardware lock is not engaged. The hardware lock is engaged when the protect-pin enable is 1 and `wp_n` is 0. A status write request made while `sr_permit` is 0 changes nothing.
- R6: A permitted request with `cs_n` low is held until `cs_n` is sampled high. On that edge bits 7, 3 and 2 of the data load into the nonvolatile bits, and `sr_cycle_start` is 1 for exactly one cycle. The other data bits are discarded.
- R7: If the hardware lock engages while a status write is still pending, the write is dropped: no bit changes and no start pulse is issued.
- R8: After a commit, `wp_n` going low does not undo the new values.
- R9: `addr_prot` for a 16-bit address: level 0 protects nothing, level 1 protects C000-FFFF, level 2 protects 8000-FFFF, level 3 protects 0000-FFFF.
- R10: With `ADDR_W` = 15, level 1 protects 6000-7FFF and level 2 protects 4000-7FFF.
- R11: `addr_prot` depends only on the level and the address, and not on the latch, `wp_n` or `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low; its high level commits a pending status write |
| wp_n | input | 1 | Write-protect pin, active low |
| wel_set | input | 1 | Set command for the write-enable latch |
| wel_clr | input | 1 | Clear command for the write-enable latch |
| sr_wr_req | input | 1 | Status write data byte received |
| sr_wr_data | input | 8 | Status write data byte |
| busy | input | 1 | Internal write cycle in progress |
| cand_addr | input | ADDR_W | Array address to classify |
| status | output | 8 | Status byte |
| sr_permit | output | 1 | A status write would be accepted now |
| sr_cycle_start | output | 1 | One-cycle pulse that starts the status write cycle |
| addr_prot | output | 1 | Candidate address lies in the protected region |

## Verification
The status byte, `sr_permit` and `addr_prot` are combinational from registered state and inputs. They are due in the same cycle that `busy`, `wp_n` or `cand_addr` change. A latch command, a busy fall or a commit takes effect one clock edge later. The bench drives every input on the falling edge and samples half a period after the next rising edge. A registered result is therefore read in the first cycle it is due, and the start pulse is checked both in its cycle and in the cycle after.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

    localparam int STAT_W  = 8;
    localparam int B_BUSY  = 0;
    localparam int B_WEL   = 1;
    localparam int B_LVL0  = 2;
    localparam int B_LVL1  = 3;
    localparam int B_PEN   = 7;

    typedef enum logic [1:0] {
        LVL_NONE = 2'b00,
        LVL_QTR  = 2'b01,
        LVL_HALF = 2'b10,
        LVL_ALL  = 2'b11
    } prot_lvl_e;

    typedef struct packed {
        logic      pin_en;
        prot_lvl_e lvl;
    } nv_bits_t;

    function automatic nv_bits_t nv_from_byte(input logic [STAT_W-1:0] d);
        nv_bits_t n;
        n.pin_en = d[B_PEN];
        n.lvl    = prot_lvl_e'({d[B_LVL1], d[B_LVL0]});
        return n;
    endfunction

    function automatic logic [STAT_W-1:0] build_status(input nv_bits_t n,
                                                       input logic wel,
                                                       input logic busy);
        logic [STAT_W-1:0] s;
        s = '0;
        if (busy) begin
            s = '1;
        end else begin
            s[B_PEN]  = n.pin_en;
            s[B_LVL1] = n.lvl[1];
            s[B_LVL0] = n.lvl[0];
            s[B_WEL]  = wel;
        end
        return s;
    endfunction

endpackage

// File: rtl/sr_guard_wel.sv
module sr_guard_wel (
    input  logic clk,
    input  logic rst,
    input  logic set_cmd,
    input  logic clr_cmd,
    input  logic busy,
    output logic wel
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel    <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            busy_q <= busy;
            if (busy) begin
                wel <= wel;
            end else if (busy_q) begin
                wel <= 1'b0;
            end else if (set_cmd) begin
                wel <= 1'b1;
            end else if (clr_cmd) begin
                wel <= 1'b0;
            end
        end
    end

    p_set_latch_r3: assert property (@(posedge clk) disable iff (rst)
        (set_cmd && !busy && !$past(busy)) |=> wel);

    p_clr_latch_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_cmd && !set_cmd && !busy) |=> !wel);

    p_end_clears_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |=> !wel);

endmodule

// File: rtl/sr_guard_nvreg.sv
module sr_guard_nvreg
    import sr_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              permit,
    input  logic              cs_n,
    input  logic              wp_n,
    output nv_bits_t          nv,
    output logic              start
);
    nv_bits_t pend;
    logic     pend_vld;
    logic     lock;

    assign lock = nv.pin_en & ~wp_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            nv       <= '0;
            pend     <= '0;
            pend_vld <= 1'b0;
            start    <= 1'b0;
        end else begin
            start <= 1'b0;
            if (pend_vld && lock) begin
                pend_vld <= 1'b0;
            end else if (pend_vld && cs_n) begin
                nv       <= pend;
                pend_vld <= 1'b0;
                start    <= 1'b1;
            end else if (wr_req && permit && !cs_n) begin
                pend     <= nv_from_byte(wr_data);
                pend_vld <= 1'b1;
            end
        end
    end

    p_lock_freezes_r7: assert property (@(posedge clk) disable iff (rst)
        (nv.pin_en && !wp_n) |=> $stable(nv));

    p_start_after_cs_r6: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(cs_n));

    p_start_single_r6: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

endmodule

// File: rtl/sr_guard_blkprot.sv
module sr_guard_blkprot
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  prot_lvl_e         lvl,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam int HI = ADDR_W - 1;
    logic [1:0] top2;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign top2 = addr[HI -: 2];
        end else begin : g_narrow
            assign top2 = {addr[0], addr[0]};
        end
    endgenerate

    always_comb begin
        unique case (lvl)
            LVL_NONE: prot = 1'b0;
            LVL_QTR:  prot = (top2 == 2'b11);
            LVL_HALF: prot = top2[1];
            LVL_ALL:  prot = 1'b1;
            default:  prot = 1'b1;
        endcase
    end

endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              sr_wr_req,
    input  logic [7:0]        sr_wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] cand_addr,
    output logic [7:0]        status,
    output logic              sr_permit,
    output logic              sr_cycle_start,
    output logic              addr_prot
);
    logic     wel;
    nv_bits_t nv;
    logic     hw_lock;

    sr_guard_wel u_wel (
        .clk     (clk),
        .rst     (rst),
        .set_cmd (wel_set),
        .clr_cmd (wel_clr),
        .busy    (busy),
        .wel     (wel)
    );

    assign hw_lock   = nv.pin_en & ~wp_n;
    assign sr_permit = wel & ~busy & ~hw_lock;

    sr_guard_nvreg u_nv (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (sr_wr_req),
        .wr_data (sr_wr_data),
        .permit  (sr_permit),
        .cs_n    (cs_n),
        .wp_n    (wp_n),
        .nv      (nv),
        .start   (sr_cycle_start)
    );

    sr_guard_blkprot #(.ADDR_W(ADDR_W)) u_blk (
        .lvl  (nv.lvl),
        .addr (cand_addr),
        .prot (addr_prot)
    );

    assign status = build_status(nv, wel, busy);

    p_start_needs_idle_r6: assert property (@(posedge clk) disable iff (rst)
        sr_cycle_start |-> !$past(busy));

    p_whole_array_r9: assert property (@(posedge clk) disable iff (rst)
        (nv.lvl == LVL_ALL) |-> addr_prot);

    p_no_region_r9: assert property (@(posedge clk) disable iff (rst)
        (nv.lvl == LVL_NONE) |-> !addr_prot);

endmodule

// File: tb/sim_sr_guard.sv
module sim_sr_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        wp_n = 1'b1;
    logic        wel_set = 1'b0;
    logic        wel_clr = 1'b0;
    logic        sr_wr_req = 1'b0;
    logic [7:0]  sr_wr_data = 8'h00;
    logic        busy = 1'b0;
    logic [15:0] addr16 = 16'h0000;
    logic [14:0] addr15 = 15'h0000;
    logic [7:0]  status, status15;
    logic        sr_permit, sr_cycle_start, addr_prot;
    logic        permit15, start15, prot15;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sr_guard #(.ADDR_W(16)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n),
        .wel_set(wel_set), .wel_clr(wel_clr),
        .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data), .busy(busy),
        .cand_addr(addr16), .status(status), .sr_permit(sr_permit),
        .sr_cycle_start(sr_cycle_start), .addr_prot(addr_prot)
    );

    sr_guard #(.ADDR_W(15)) u1 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n),
        .wel_set(wel_set), .wel_clr(wel_clr),
        .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data), .busy(busy),
        .cand_addr(addr15), .status(status15), .sr_permit(permit15),
        .sr_cycle_start(start15), .addr_prot(prot15)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_latch();
        wel_set = 1'b1;
        tick();
        wel_set = 1'b0;
    endtask

    // request byte with cs low, then raise cs; returns at the commit cycle
    task automatic sr_write(input logic [7:0] d);
        cs_n = 1'b0; sr_wr_req = 1'b1; sr_wr_data = d;
        tick();
        sr_wr_req = 1'b0; cs_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R3 reset status", status, 8'h00);
        check("R5 reset permit", sr_permit, 1'b0);
        addr16 = 16'hFFFF; #1;
        check("R9 reset no protection", addr_prot, 1'b0);
    endtask

    task automatic t_latch();
        set_latch();
        check("R3 set latch", status, 8'h02);
        check("R5 permit with latch", sr_permit, 1'b1);
        wp_n = 1'b0; wel_clr = 1'b1;
        tick();
        wel_clr = 1'b0; wp_n = 1'b1;
        check("R3 clear with wp low", status, 8'h00);
    endtask

    task automatic t_commit_and_busy();
        set_latch();
        sr_write(8'hFC);
        check("R6 start pulse", sr_cycle_start, 1'b1);
        check("R1 R6 status after commit", status, 8'h8E);
        tick();
        check("R6 start one cycle", sr_cycle_start, 1'b0);
        busy = 1'b1; #1;
        check("R2 busy reads ones", status, 8'hFF);
        check("R5 no permit while busy", sr_permit, 1'b0);
        tick(); tick();
        busy = 1'b0;
        tick();
        check("R4 latch cleared at end", status, 8'h8C);
    endtask

    task automatic t_hw_lock();
        set_latch();
        wp_n = 1'b0; #1;
        check("R5 lock removes permit", sr_permit, 1'b0);
        sr_write(8'h00);
        check("R5 locked write no start", sr_cycle_start, 1'b0);
        tick();
        check("R5 locked write no change", status, 8'h8E);
        wp_n = 1'b1;
        cs_n = 1'b0; sr_wr_req = 1'b1; sr_wr_data = 8'h00;
        tick();
        sr_wr_req = 1'b0; wp_n = 1'b0;
        tick();
        cs_n = 1'b1;
        tick();
        check("R7 aborted no start", sr_cycle_start, 1'b0);
        tick();
        wp_n = 1'b1;
        check("R7 aborted no change", status, 8'h8E);
    endtask

    task automatic t_after_commit();
        sr_write(8'h04);
        check("R6 start level 1", sr_cycle_start, 1'b1);
        wp_n = 1'b0;
        tick(); tick();
        check("R8 commit kept", status, 8'h06);
        check("R5 pin ignored when enable 0", sr_permit, 1'b1);
        wp_n = 1'b1;
    endtask

    task automatic t_ranges();
        addr16 = 16'hBFFF; addr15 = 15'h5FFF; #1;
        check("R9 quarter below", addr_prot, 1'b0);
        check("R10 quarter below 15b", prot15, 1'b0);
        addr16 = 16'hC000; addr15 = 15'h6000; #1;
        check("R9 quarter start", addr_prot, 1'b1);
        check("R10 quarter start 15b", prot15, 1'b1);
        sr_write(8'h08);
        addr16 = 16'h7FFF; addr15 = 15'h3FFF; #1;
        check("R9 half below", addr_prot, 1'b0);
        check("R10 half below 15b", prot15, 1'b0);
        addr16 = 16'h8000; addr15 = 15'h4000; #1;
        check("R9 half start", addr_prot, 1'b1);
        check("R10 half start 15b", prot15, 1'b1);
        tick(); tick();
        wel_clr = 1'b1; tick(); wel_clr = 1'b0;
        wp_n = 1'b0; busy = 1'b1; #1;
        check("R11 prot independent", addr_prot, 1'b1);
        addr16 = 16'h0000; #1;
        check("R11 unprot independent", addr_prot, 1'b0);
        busy = 1'b0; wp_n = 1'b1;
        tick();
        set_latch();
        sr_write(8'h0C);
        #1;
        check("R9 all protected", addr_prot, 1'b1);
        tick();
        set_latch();
        sr_write(8'h00);
        addr16 = 16'hFFFF; #1;
        check("R9 none protected", addr_prot, 1'b0);
        check("R1 unused bits discarded", status, 8'h02);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_latch();
        t_commit_and_busy();
        t_hw_lock();
        t_after_commit();
        t_ranges();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule